// File: doc/BRIEF.md
# Status Byte Service Request Logic

This block is the top of a status reporting tree. Seven summary flags, each driven by a lower event register or queue, form a live 8-bit status byte; the flag from the output queue sits at bit 4 and says that a response is waiting. A writable service request enable mask selects which of these flags may ask for service. When any enabled flag is set, the master summary is high. A rising master summary latches a request-service bit, which drives the active-high `srq` interrupt line.

Two read views are offered. The poll view carries the latched request-service bit at position 6. A poll strobe clears that latch, so a later enabled event can raise `srq` again. The query view carries the live master summary at position 6. A query strobe changes nothing. The request latch is a three-state machine: `ST_ARMED` (no request, master summary low), `ST_PENDING` (request latched, `srq` high) and `ST_DRAINED` (request polled away while the master summary is still high). The transitions are named as follows. `ARMED->PENDING` happens on a rise. `PENDING->DRAINED` happens on a poll while the summary stays high. `PENDING->ARMED` happens on a poll while the summary is low. `PENDING->PENDING` happens on a poll that meets a fresh rise. `DRAINED->ARMED` happens when the summary falls.

Top module: `svc_status_byte`

## Requirements
- R1: Bits 0-5 of both read values equal `sum_in[5:0]`, and bit 7 equals `sum_in[6]`, in the same cycle without storage. For example, `sum_in` bits 4 and 5 alone give the value 48.
- R2: A write strobe `en_wr` loads `en_wdata` into the enable mask at the next clock edge. `en_rdata` returns the mask with bit 6 always 0.
- R3: Bit 6 of `query_data` is the OR over bits 0-5 and 7 of the status byte ANDed with the mask, in the same cycle.
- R4: The request latch sets at the clock edge where the master summary is high and was low at the previous edge (reset counts as low). `srq` and bit 6 of `poll_data` then read 1 from the following cycle onward.
- R5: A `poll_rd` cycle returns the pre-clear request bit in `poll_data`. From the next cycle `srq` is 0, unless R8 applies.
- R6: A `query_rd` strobe leaves `srq`, the mask and both read values unchanged.
- R7: After a poll has cleared the request, `srq` stays 0 while the master summary stays high. It rises again only after the summary has fallen and risen.
- R8: If a poll and a master summary rise fall on the same edge, the poll still reads the pre-clear bit, and `srq` is 1 afterwards.
- R9: A synchronous reset `rst` clears the mask and the request latch, so `srq` is 0 after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sum_in | input | 7 | Summary flags for status bits 0-5 and 7 (bit 4 is message available) |
| en_wr | input | 1 | Enable mask write strobe |
| en_wdata | input | 8 | Enable mask write data |
| en_rdata | output | 8 | Enable mask read-back, bit 6 is 0 |
| poll_rd | input | 1 | Serial-poll read strobe, clears the request latch |
| query_rd | input | 1 | Query status read strobe, no side effects |
| poll_data | output | 8 | Status byte with request-service at bit 6 |
| query_data | output | 8 | Status byte with master summary at bit 6 |
| srq | output | 1 | Service request interrupt, active high |

## Verification
The assertions assume that `sum_in`, the strobes and the write data are stable across each rising edge and carry known values once reset has been released. They also assume that reset lasts at least one edge before the first check. The bench changes every input on the falling clock edge and holds reset for several cycles at the start. It drives the poll and query strobes as single-cycle pulses, so each strobe meets exactly one edge. The simultaneous poll-and-rise case is built on purpose: the bench drops the summary for one cycle before raising it in the poll cycle, so the edge detector sees a genuine rise.

// File: rtl/svc_pkg.sv
package svc_pkg;
    localparam int SB_W    = 8;
    localparam int RQS_POS = 6;
    localparam int MAV_POS = 4;
    localparam int SUM_W   = SB_W - 1;

    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_PENDING = 2'd1,
        ST_DRAINED = 2'd2
    } rqs_state_t;
endpackage

// File: rtl/svc_enable_reg.sv
module svc_enable_reg #(
    parameter int W    = 8,
    parameter int HOLE = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic hole_unused;
    assign hole_unused = wdata[HOLE];

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == HOLE) begin : g_hole
            assign q[i] = 1'b0;
        end else begin : g_store
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst)
                    bit_q <= 1'b0;
                else if (wr)
                    bit_q <= wdata[i];
            end
            assign q[i] = bit_q;
        end
    end

    a_r2_mask_load: assert property (@(posedge clk) disable iff (rst)
        wr |=> (q == ($past(wdata) & ~(W'(1) << HOLE))));
endmodule

// File: rtl/svc_summary.sv
module svc_summary #(
    parameter int W    = 8,
    parameter int HOLE = 6
) (
    input  logic [W-1:0] status,
    input  logic [W-1:0] enable,
    output logic         mss
);
    logic [W-1:0] hits;
    for (genvar i = 0; i < W; i++) begin : g_hit
        if (i == HOLE) begin : g_skip
            assign hits[i] = 1'b0;
        end else begin : g_and
            assign hits[i] = status[i] & enable[i];
        end
    end
    assign mss = |hits;
endmodule

// File: rtl/svc_rqs_fsm.sv
module svc_rqs_fsm
    import svc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mss,
    input  logic poll,
    input  logic query,
    output logic srq
);
    rqs_state_t state, state_nx;
    logic       mss_q;
    logic       rise;

    assign rise = mss & ~mss_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_ARMED;
            mss_q <= 1'b0;
        end else begin
            state <= state_nx;
            mss_q <= mss;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ARMED:
                if (rise) state_nx = ST_PENDING;
            ST_PENDING:
                if (poll) begin
                    if (rise)     state_nx = ST_PENDING;
                    else if (mss) state_nx = ST_DRAINED;
                    else          state_nx = ST_ARMED;
                end
            ST_DRAINED:
                if (!mss) state_nx = ST_ARMED;
            default:
                state_nx = ST_ARMED;
        endcase
    end

    always_comb begin
        srq = 1'b0;
        unique case (state)
            ST_PENDING: srq = 1'b1;
            default:    srq = 1'b0;
        endcase
    end

    a_r4_set_needs_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(srq) |-> $past(mss));
    a_r5_poll_clears: assert property (@(posedge clk) disable iff (rst)
        (poll && srq && !rise) |=> !srq);
    a_r6_query_inert: assert property (@(posedge clk) disable iff (rst)
        (query && !poll && srq) |=> srq);
    a_r7_no_retrigger: assert property (@(posedge clk) disable iff (rst)
        (!srq && mss && mss_q) |=> !srq);
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        (poll && rise) |=> srq);
    a_r4_armed_low: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED) |-> !mss_q);
endmodule

// File: rtl/svc_status_byte.sv
module svc_status_byte
    import svc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SUM_W-1:0] sum_in,
    input  logic             en_wr,
    input  logic [SB_W-1:0]  en_wdata,
    output logic [SB_W-1:0]  en_rdata,
    input  logic             poll_rd,
    input  logic             query_rd,
    output logic [SB_W-1:0]  poll_data,
    output logic [SB_W-1:0]  query_data,
    output logic             srq
);
    logic [SB_W-1:0] live;
    logic            mss;

    for (genvar i = 0; i < SB_W; i++) begin : g_map
        if (i < RQS_POS) begin : g_low
            assign live[i] = sum_in[i];
        end else if (i == RQS_POS) begin : g_gap
            assign live[i] = 1'b0;
        end else begin : g_high
            assign live[i] = sum_in[i-1];
        end
    end

    svc_enable_reg #(.W(SB_W), .HOLE(RQS_POS)) u_en (
        .clk   (clk),
        .rst   (rst),
        .wr    (en_wr),
        .wdata (en_wdata),
        .q     (en_rdata)
    );

    svc_summary #(.W(SB_W), .HOLE(RQS_POS)) u_sum (
        .status (live),
        .enable (en_rdata),
        .mss    (mss)
    );

    svc_rqs_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .mss   (mss),
        .poll  (poll_rd),
        .query (query_rd),
        .srq   (srq)
    );

    always_comb begin
        query_data          = live;
        query_data[RQS_POS] = mss;
        poll_data           = live;
        poll_data[RQS_POS]  = srq;
    end

    a_r1_live_mav: assert property (@(posedge clk) disable iff (rst)
        (poll_data[MAV_POS] == sum_in[MAV_POS]) && (query_data[MAV_POS] == sum_in[MAV_POS]));
    a_r9_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!srq && en_rdata == '0));
endmodule

// File: tb/sim_svc_status_byte.sv
module sim_svc_status_byte;
    logic       clk = 1'b0;
    logic       rst;
    logic [6:0] sum_in;
    logic       en_wr;
    logic [7:0] en_wdata;
    logic [7:0] en_rdata;
    logic       poll_rd;
    logic       query_rd;
    logic [7:0] poll_data;
    logic [7:0] query_data;
    logic       srq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    svc_status_byte u0 (
        .clk(clk), .rst(rst), .sum_in(sum_in), .en_wr(en_wr), .en_wdata(en_wdata),
        .en_rdata(en_rdata), .poll_rd(poll_rd), .query_rd(query_rd),
        .poll_data(poll_data), .query_data(query_data), .srq(srq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_en(input logic [7:0] v);
        @(negedge clk);
        en_wr = 1'b1; en_wdata = v;
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    task automatic test_reset();
        chk("R9 srq after reset", {7'd0, srq}, 8'd0);
        chk("R9 mask after reset", en_rdata, 8'd0);
        chk("R9 query bit6 after reset", query_data, 8'd0);
    endtask

    task automatic test_live();
        @(negedge clk); sum_in = 7'b0110000;
        #1;
        chk("R1 query bits4+5", query_data, 8'd48);
        chk("R1 poll bits4+5", poll_data, 8'd48);
        @(negedge clk); sum_in = 7'b1000001;
        #1;
        chk("R1 bit7 mapping", query_data, 8'd129);
        @(negedge clk); sum_in = 7'b0100000;
        #1;
        chk("R1 MAV drops", poll_data, 8'd32);
        @(negedge clk); sum_in = 7'd0;
    endtask

    task automatic test_mask();
        write_en(8'hFF);
        chk("R2 mask bit6 zero", en_rdata, 8'hBF);
        write_en(8'h00);
        chk("R2 mask cleared", en_rdata, 8'h00);
    endtask

    task automatic test_raise();
        @(negedge clk); sum_in = 7'b0010000;
        write_en(8'h10);
        chk("R3 query mss", query_data, 8'd80);
        chk("R4 srq not yet", {7'd0, srq}, 8'd0);
        @(negedge clk);
        chk("R4 srq set", {7'd0, srq}, 8'd1);
        chk("R4 poll bit6", poll_data, 8'd80);
    endtask

    task automatic test_query();
        @(negedge clk); query_rd = 1'b1;
        #1;
        chk("R6 query value", query_data, 8'd80);
        @(negedge clk); query_rd = 1'b0;
        chk("R6 srq kept", {7'd0, srq}, 8'd1);
        chk("R6 poll kept", poll_data, 8'd80);
    endtask

    task automatic test_poll();
        @(negedge clk); poll_rd = 1'b1;
        #1;
        chk("R5 poll pre-clear", poll_data, 8'd80);
        @(negedge clk); poll_rd = 1'b0;
        chk("R5 srq cleared", {7'd0, srq}, 8'd0);
        chk("R5 poll after", poll_data, 8'd16);
        chk("R5 query still mss", query_data, 8'd80);
    endtask

    task automatic test_retrigger();
        repeat (3) @(negedge clk);
        chk("R7 no retrigger", {7'd0, srq}, 8'd0);
        sum_in = 7'd0;
        @(negedge clk); sum_in = 7'b0010000;
        @(negedge clk);
        chk("R7 retrigger after fall", {7'd0, srq}, 8'd1);
    endtask

    task automatic test_priority();
        @(negedge clk); sum_in = 7'd0;
        @(negedge clk); sum_in = 7'b0010000; poll_rd = 1'b1;
        #1;
        chk("R8 poll reads pre-clear", poll_data, 8'd80);
        @(negedge clk); poll_rd = 1'b0;
        chk("R8 set wins", {7'd0, srq}, 8'd1);
        @(negedge clk); poll_rd = 1'b1;
        @(negedge clk); poll_rd = 1'b0;
        chk("R5 later poll clears", {7'd0, srq}, 8'd0);
    endtask

    task automatic test_midreset();
        @(negedge clk); sum_in = 7'd0;
        @(negedge clk); sum_in = 7'b0010000;
        @(negedge clk);
        chk("R4 pending before reset", {7'd0, srq}, 8'd1);
        rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R9 srq reset", {7'd0, srq}, 8'd0);
        chk("R9 mask reset", en_rdata, 8'd0);
    endtask

    initial begin
        rst = 1'b1; sum_in = '0; en_wr = 1'b0; en_wdata = '0;
        poll_rd = 1'b0; query_rd = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_live();
        test_mask();
        test_raise();
        test_query();
        test_poll();
        test_retrigger();
        test_priority();
        test_midreset();
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule